// File: doc/BRIEF.md
# Infrared FIR 4PPM Frame Chip Sequencer

This block drives the transmit line of a 4 Mbit/s infrared link. It turns one frame into a stream of chips, with one chip issued for each pulse of an 8 MHz chip-rate enable. A frame goes out as a fixed preamble, then a fixed start flag, then the payload bytes in four-position pulse-position code, then a fixed stop flag. Payload arrives one byte at a time through a valid/ready handshake. A last marker closes the frame. The block computes no check sequence. Any such bytes come from upstream and are sent as ordinary payload.

When the transmitter is idle, it can also send a serial interaction pulse. This is one high level whose length is a number of chip periods set by an input, and a separate enable input gates it. While the block enable is low, the line stays low and any frame in progress is dropped. This keeps the line free of spurious pulses while the surrounding logic is being reconfigured.

Top module: `irfir_chip_tx`

## Requirements
- R1: After a frame starts (in_valid high while idle and enabled), the first 256 chips are the 16-chip word 1000000010101000 repeated 16 times, with the leftmost chip sent first.
- R2: The next 32 chips are 00001100000011000110000001100000, leftmost first.
- R3: Each payload byte becomes 16 chips, taking bit pairs from bits [1:0] up to bits [7:6]. A pair of value v becomes four chips in which only position v (0 = first) is high: 00→1000, 01→0100, 10→0010, 11→0001. No chips are inserted between bytes or before the stop flag.
- R4: in_ready is high only in a chip-enable cycle in which the first chip of a new payload byte is due. A byte is taken when in_valid and in_ready are both high. Exactly one byte is taken per 16 payload chips.
- R5: After the byte marked by in_last, the next 32 chips are 00001100000011000000011000000110, leftmost first. busy then drops and the line is low.
- R6: If in_valid is low when a byte is due, the stop flag starts in that chip slot and the frame ends after it. No further payload is sent.
- R7: While enable is low, tx_chip and busy are low from the next clock, in_ready is low, and any frame is abandoned.
- R8: tx_chip changes only on a clock edge at which chip_en was high, or on one that follows a cycle with enable low.
- R9: While idle, with sip_enable high and a sip_req, the line goes high for sip_chips chip periods and then low, with busy high throughout. A length of 0 gives no high chip.
- R10: sip_req has no effect while sip_enable is low or while a frame runs. If in_valid and sip_req arrive together while idle, the frame wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low forces the line idle |
| chip_en | input | 1 | One-cycle chip-rate strobe |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte taken this cycle if valid |
| in_data | input | DATA_W | Payload byte |
| in_last | input | 1 | Byte is the last of the frame |
| sip_enable | input | 1 | Permits interaction pulses |
| sip_req | input | 1 | Request for one interaction pulse |
| sip_chips | input | SIP_W | Pulse length in chip periods |
| tx_chip | output | 1 | Transmit chip line |
| busy | output | 1 | A frame or pulse is in progress |

## Verification
A wrong phase or chip counter shows up as a misplaced chip on tx_chip within one chip period. Such an error breaks the exact preamble or flag comparison, or it leaves a four-chip group without exactly one high chip, and the bench's decoder rejects that group. A stale byte register shows as a wrongly decoded byte at the next payload group. A handshake fault shows as a mismatch between the number of bytes taken and the number of payload groups seen before the stop flag. A fault in the disable path shows on the very next clock as a high line or busy flag.

// File: rtl/irfir_pkg.sv
package irfir_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_STA,
        PH_DATA,
        PH_STO,
        PH_SIP
    } phase_e;

    typedef enum logic [1:0] {
        FL_PRE,
        FL_STA,
        FL_STO
    } flag_e;

    localparam int PRE_WORD_LEN = 16;
    localparam int FLAG_LEN     = 32;

    // leftmost (MSB) chip is transmitted first
    localparam logic [PRE_WORD_LEN-1:0] PRE_WORD = 16'b1000_0000_1010_1000;
    localparam logic [FLAG_LEN-1:0]     STA_WORD = 32'b0000_1100_0000_1100_0110_0000_0110_0000;
    localparam logic [FLAG_LEN-1:0]     STO_WORD = 32'b0000_1100_0000_1100_0000_0110_0000_0110;

endpackage

// File: rtl/irfir_flag_rom.sv
module irfir_flag_rom
    import irfir_pkg::*;
(
    input  flag_e      sel_i,
    input  logic [4:0] idx_i,
    output logic       chip_o
);

    logic [3:0] pre_bit;
    logic [4:0] flg_bit;

    always_comb begin
        pre_bit = 4'd15 - idx_i[3:0];
        flg_bit = 5'd31 - idx_i;
        case (sel_i)
            FL_PRE:  chip_o = PRE_WORD[pre_bit];
            FL_STA:  chip_o = STA_WORD[flg_bit];
            default: chip_o = STO_WORD[flg_bit];
        endcase
    end

endmodule

// File: rtl/irfir_ppm_map.sv
module irfir_ppm_map #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]             byte_i,
    input  logic [$clog2(DATA_W*2)-1:0]   pos_i,
    output logic                          chip_o
);

    localparam int POS_W  = $clog2(DATA_W*2);
    localparam int SYMS   = DATA_W / 2;
    localparam int SYM_IW = POS_W - 2;

    logic [1:0] sym;

    always_comb begin
        sym = 2'b00;
        for (int k = 0; k < SYMS; k++) begin
            if (pos_i[POS_W-1:2] == SYM_IW'(k)) begin
                sym = byte_i[2*k +: 2];
            end
        end
        chip_o = (pos_i[1:0] == sym);
    end

endmodule

// File: rtl/irfir_chip_tx.sv
module irfir_chip_tx
    import irfir_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRE_REPS = 16,
    parameter int SIP_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              chip_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              sip_enable,
    input  logic              sip_req,
    input  logic [SIP_W-1:0]  sip_chips,
    output logic              tx_chip,
    output logic              busy
);

    localparam int PRE_TOTAL  = PRE_REPS * PRE_WORD_LEN;
    localparam int BYTE_CHIPS = DATA_W * 2;
    localparam int POS_W      = $clog2(BYTE_CHIPS);
    localparam int W_A        = $clog2(PRE_TOTAL);
    localparam int W_B        = (W_A > SIP_W) ? W_A : SIP_W;
    localparam int W_C        = (W_B > POS_W) ? W_B : POS_W;
    localparam int CNT_W      = (W_C > 5) ? W_C : 5;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  byte_v;
        logic               last;
        logic               tx;
    } regs_t;

    regs_t r_d, r_q;

    flag_e             flag_sel;
    logic              flag_chip;
    logic [DATA_W-1:0] ppm_byte;
    logic              ppm_chip;
    logic              first_slot;

    assign first_slot = (r_q.cnt == '0);
    assign ppm_byte   = first_slot ? in_data : r_q.byte_v;

    always_comb begin
        case (r_q.phase)
            PH_PRE:  flag_sel = FL_PRE;
            PH_STA:  flag_sel = FL_STA;
            default: flag_sel = FL_STO;
        endcase
    end

    irfir_flag_rom u_flag (
        .sel_i  (flag_sel),
        .idx_i  (r_q.cnt[4:0]),
        .chip_o (flag_chip)
    );

    irfir_ppm_map #(.DATA_W(DATA_W)) u_ppm (
        .byte_i (ppm_byte),
        .pos_i  (r_q.cnt[POS_W-1:0]),
        .chip_o (ppm_chip)
    );

    always_comb begin
        r_d      = r_q;
        in_ready = 1'b0;
        if (!enable) begin
            r_d = '0;
        end else begin
            case (r_q.phase)
                PH_IDLE: begin
                    r_d.tx  = 1'b0;
                    r_d.cnt = '0;
                    if (in_valid) begin
                        r_d.phase = PH_PRE;
                    end else if (sip_enable && sip_req) begin
                        r_d.phase = PH_SIP;
                    end
                end
                PH_PRE: begin
                    if (chip_en) begin
                        r_d.tx = flag_chip;
                        if (r_q.cnt == CNT_W'(PRE_TOTAL - 1)) begin
                            r_d.phase = PH_STA;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                PH_STA: begin
                    if (chip_en) begin
                        r_d.tx = flag_chip;
                        if (r_q.cnt == CNT_W'(FLAG_LEN - 1)) begin
                            r_d.phase = PH_DATA;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                PH_DATA: begin
                    if (chip_en) begin
                        if (first_slot) begin
                            in_ready = 1'b1;
                            r_d.cnt  = CNT_W'(1);
                            if (in_valid) begin
                                r_d.byte_v = in_data;
                                r_d.last   = in_last;
                                r_d.tx     = ppm_chip;
                            end else begin
                                // underrun: stop flag takes this slot
                                r_d.tx    = flag_chip;
                                r_d.phase = PH_STO;
                            end
                        end else begin
                            r_d.tx = ppm_chip;
                            if (r_q.cnt == CNT_W'(BYTE_CHIPS - 1)) begin
                                r_d.cnt = '0;
                                if (r_q.last) begin
                                    r_d.phase = PH_STO;
                                end
                            end else begin
                                r_d.cnt = r_q.cnt + CNT_W'(1);
                            end
                        end
                    end
                end
                PH_STO: begin
                    if (chip_en) begin
                        r_d.tx = flag_chip;
                        if (r_q.cnt == CNT_W'(FLAG_LEN - 1)) begin
                            r_d.phase = PH_IDLE;
                            r_d.cnt   = '0;
                            r_d.last  = 1'b0;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                PH_SIP: begin
                    if (chip_en) begin
                        if (r_q.cnt < CNT_W'(sip_chips)) begin
                            r_d.tx  = 1'b1;
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end else begin
                            r_d.tx    = 1'b0;
                            r_d.cnt   = '0;
                            r_d.phase = PH_IDLE;
                        end
                    end
                end
                default: r_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_chip = r_q.tx;
    assign busy    = (r_q.phase != PH_IDLE);

endmodule

// File: rtl/irfir_chip_tx_chk.sv
module irfir_chip_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic chip_en,
    input logic in_valid,
    input logic in_ready,
    input logic sip_enable,
    input logic tx_chip,
    input logic busy
);

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tx_chip && !busy));

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_chip);

    p_chip_paced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !chip_en) |=> $stable(tx_chip));

    p_ready_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && chip_en && enable));

    p_sip_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sip_enable && !in_valid) |=> !busy);

endmodule

bind irfir_chip_tx irfir_chip_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .chip_en    (chip_en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sip_enable (sip_enable),
    .tx_chip    (tx_chip),
    .busy       (busy)
);

// File: tb/sim_irfir_chip_tx.sv
module sim_irfir_chip_tx;

    localparam logic [15:0] T_PRE = 16'b1000_0000_1010_1000;
    localparam logic [31:0] T_STA = 32'b0000_1100_0000_1100_0110_0000_0110_0000;
    localparam logic [31:0] T_STO = 32'b0000_1100_0000_1100_0000_0110_0000_0110;

    localparam int VEC_N = 5;
    localparam int V_LEN [VEC_N] = '{1, 3, 4, 2, 4};
    localparam int V_CUT [VEC_N] = '{99, 99, 99, 99, 2};
    localparam logic [7:0] PAY [16] = '{8'h00, 8'hFF, 8'h1B, 8'hE4, 8'h55, 8'hAA,
                                        8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'h81, 8'h7E,
                                        8'h12, 8'h34, 8'h56, 8'h78};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       chip_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       sip_enable = 1'b0;
    logic       sip_req = 1'b0;
    logic [7:0] sip_chips = 8'd13;
    logic       tx_chip;
    logic       busy;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    irfir_chip_tx u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chip_en(chip_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .sip_enable(sip_enable), .sip_req(sip_req), .sip_chips(sip_chips),
        .tx_chip(tx_chip), .busy(busy)
    );

    always #4 clk = ~clk;

    int cdiv = 0;
    always @(negedge clk) begin
        chip_en = (cdiv == 3);
        cdiv = (cdiv + 1) % 4;
    end

    // chip capture
    logic rec [0:1023];
    int   cap_n = 0;
    logic grab = 1'b0;
    logic grab_any = 1'b0;
    logic en_edge = 1'b0;
    logic tx_prev = 1'b0;
    int   pace_bad = 0;
    int   ready_bad = 0;
    bit   busy_seen = 1'b0;

    always @(posedge clk) begin
        grab     <= chip_en && busy;
        grab_any <= chip_en;
        en_edge  <= enable;
    end

    always @(negedge clk) begin
        if (grab && cap_n < 1024) begin
            rec[cap_n] = tx_chip;
            cap_n++;
        end
        if (rst_n && en_edge && (tx_chip !== tx_prev) && !grab_any) pace_bad++;
        if (in_ready && !busy) ready_bad++;
        if (busy) busy_seen = 1'b1;
        tx_prev = tx_chip;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    task automatic send_frame(input int base, input int n, input int cut, output int moved);
        int idx;
        idx = 0;
        in_data  = PAY[base];
        in_last  = (n == 1);
        in_valid = 1'b1;
        while (in_valid) begin
            @(negedge clk); #1;
            if (in_ready) begin
                @(posedge clk); #1;
                idx++;
                if (idx >= n || idx >= cut) begin
                    in_valid = 1'b0;
                    in_last  = 1'b0;
                end else begin
                    in_data = PAY[base + idx];
                    in_last = (idx == n - 1);
                end
            end
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        moved = idx;
    endtask

    // compares the captured stream with a frame carrying m bytes from PAY[base]
    task automatic check_frame(input int base, input int m, input string end_req);
        int bad;
        int pos;
        bad = 0;
        chk(cap_n == 320 + 16 * m, end_req, "frame chip count", cap_n, 320 + 16 * m);
        for (int i = 0; i < 256; i++) if (rec[i] !== T_PRE[15 - (i % 16)]) bad++;
        chk(bad == 0, "R1", "preamble chip mismatches", bad, 0);
        bad = 0;
        for (int i = 0; i < 32; i++) if (rec[256 + i] !== T_STA[31 - i]) bad++;
        chk(bad == 0, "R2", "start flag chip mismatches", bad, 0);
        for (int j = 0; j < m; j++) begin
            logic [7:0] got;
            int ones;
            got = 8'h00;
            ones = 0;
            for (int s = 0; s < 4; s++) begin
                pos = 0;
                for (int c = 0; c < 4; c++) begin
                    if (rec[288 + 16 * j + 4 * s + c] === 1'b1) begin
                        ones++;
                        pos = c;
                    end
                end
                got[2 * s +: 2] = pos[1:0];
            end
            chk(ones == 4, "R3", "one high chip per symbol group", ones, 4);
            chk(got == PAY[base + j], "R3", "decoded payload byte", got, PAY[base + j]);
        end
        bad = 0;
        for (int i = 0; i < 32; i++) if (rec[288 + 16 * m + i] !== T_STO[31 - i]) bad++;
        chk(bad == 0, end_req, "stop flag chip mismatches", bad, 0);
    endtask

    task automatic run_sip(input int len);
        cap_n = 0;
        sip_chips = 8'(len);
        @(posedge clk); #1;
        sip_req = 1'b1;
        @(posedge clk); #1;
        sip_req = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cap_n == len + 1, "R9", "pulse chip slots", cap_n, len + 1);
        for (int i = 0; i < len; i++)
            chk(rec[i] === 1'b1, "R9", "pulse chip high", int'(rec[i]), 1);
        chk(rec[len] === 1'b0, "R9", "pulse trailing low", int'(rec[len]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog run did not finish");
        finish_run();
    end

    initial begin
        int base;
        int moved;
        int exp_m;
        repeat (4) @(posedge clk);
        #1;
        chk(tx_chip === 1'b0, "R7", "reset line", int'(tx_chip), 0);
        chk(busy === 1'b0, "R7", "reset busy", int'(busy), 0);
        chk(in_ready === 1'b0, "R4", "reset ready", int'(in_ready), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        // vector table walk
        base = 0;
        for (int v = 0; v < VEC_N; v++) begin
            cap_n = 0;
            send_frame(base, V_LEN[v], V_CUT[v], moved);
            exp_m = (V_LEN[v] < V_CUT[v]) ? V_LEN[v] : V_CUT[v];
            chk(moved == exp_m, "R4", "bytes taken by handshake", moved, exp_m);
            check_frame(base, exp_m, (V_CUT[v] < V_LEN[v]) ? "R6" : "R5");
            chk(tx_chip === 1'b0 && busy === 1'b0, "R5", "idle after frame",
                int'(tx_chip) + 2 * int'(busy), 0);
            base += V_LEN[v];
        end

        // interaction pulses
        sip_enable = 1'b1;
        run_sip(13);
        run_sip(3);
        run_sip(0);

        // gated pulse has no effect
        sip_enable = 1'b0;
        busy_seen = 1'b0;
        @(posedge clk); #1;
        sip_req = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        sip_req = 1'b0;
        chk(!busy_seen, "R10", "gated request left block idle", int'(busy_seen), 0);
        chk(tx_chip === 1'b0, "R10", "gated request line", int'(tx_chip), 0);

        // frame and pulse together: frame wins, pulse lost
        sip_enable = 1'b1;
        cap_n = 0;
        sip_req = 1'b1;
        fork
            begin
                @(posedge clk); #1;
                sip_req = 1'b0;
            end
        join_none
        send_frame(14, 2, 99, moved);
        check_frame(14, 2, "R10");
        busy_seen = 1'b0;
        repeat (40) @(negedge clk);
        chk(!busy_seen, "R10", "no pulse after frame", int'(busy_seen), 0);
        sip_enable = 1'b0;

        // disable mid frame
        @(posedge clk); #1;
        in_data = 8'hA5;
        in_last = 1'b1;
        in_valid = 1'b1;
        repeat (300) @(posedge clk);
        #1;
        enable = 1'b0;
        @(posedge clk); #1;
        chk(tx_chip === 1'b0, "R7", "line low when disabled", int'(tx_chip), 0);
        chk(busy === 1'b0, "R7", "busy low when disabled", int'(busy), 0);
        chk(in_ready === 1'b0, "R7", "ready low when disabled", int'(in_ready), 0);
        repeat (20) @(posedge clk);
        #1;
        chk(busy === 1'b0, "R7", "stays idle while disabled", int'(busy), 0);
        in_valid = 1'b0;
        in_last = 1'b0;
        enable = 1'b1;

        // clean frame after re-enable
        cap_n = 0;
        send_frame(0, 2, 99, moved);
        check_frame(0, 2, "R5");

        chk(pace_bad == 0, "R8", "line changes without chip strobe", pace_bad, 0);
        chk(ready_bad == 0, "R4", "ready outside frame", ready_bad, 0);
        finish_run();
    end

endmodule